// File: doc/BRIEF.md
# Sector Sync Tracker with Interpolation

This block keeps sector framing on a byte stream coming out of an optical-disc data path. An upstream pattern matcher flags the byte that carries a sync pattern. The tracker counts valid bytes from each sector start and compares every sync against the position where it is due. When syncs are missing or misplaced, the tracker keeps framing going. A missing sync is replaced by an interpolated sector start. A misplaced sync is either thrown away or used to restart the count, depending on a policy input.

Each accepted or interpolated sector start produces a one-cycle pulse. The tracker also reports whether that start was interpolated and whether the sector that just closed was short or long. Anomalies are stored in sticky cause bits that drive a level interrupt request. Software clears the cause bits by writing ones to the acknowledge input.

The position of a byte is the number of valid bytes since the current sector's first byte, which sits at position 0. The nominal length is `SECTOR_LEN` bytes, so the next sync is due at position `SECTOR_LEN`. The effective long window is `min(cfg_long_win, MAX_WIN)`.

Top module: `sst_tracker`

## Requirements
- R1: When reset is released, the tracker is unlocked and `sof`, `sof_interp`, `sec_short`, `sec_long`, `cause` and `irq` are all 0.
- R2: While unlocked, valid bytes without a sync have no effect. The first valid byte carrying a sync is accepted unconditionally: it gives a sector start with `sof_interp`=0, locks the tracker and sets no cause bit.
- R3: While locked, a sync at position `SECTOR_LEN` gives a normal sector start. It sets no cause bit and sets both `sec_short` and `sec_long` to 0.
- R4: With `cfg_resync`=0, a sync at a position from 1 to `SECTOR_LEN`-1 is discarded. Framing continues on the count, and cause bit 0 (ignored) is set.
- R5: With no sync at position `SECTOR_LEN`, when `cfg_resync`=0 or the effective window is 0, that byte becomes an interpolated sector start. `sof_interp`=1, cause bit 1 (interpolated) is set, and both size flags are 0.
- R6: With `cfg_resync`=1, a sync at a position from 1 to `SECTOR_LEN`-1 restarts the sector at that byte. `sof_interp`=0, cause bits 2 (resync) and 3 (short) are set, and `sec_short`=1 and `sec_long`=0.
- R7: With `cfg_resync`=1 and an effective window W>0, a missing sync at position `SECTOR_LEN` extends the sector. A sync at position `SECTOR_LEN`+k, with 1<=k<=W, restarts the sector there. Cause bits 2 and 4 (long) are set, and `sec_long`=1 and `sec_short`=0.
- R8: If an extended sector reaches position `SECTOR_LEN`+W with no sync, that byte becomes an interpolated start. Cause bits 1 and 4 are set and `sec_long`=1. A `cfg_long_win` value above `MAX_WIN` acts as `MAX_WIN`.
- R9: `irq` equals the OR of the cause bits. A 1 on `ack[i]` clears cause bit i. If an event sets a bit in the same cycle, the set wins.
- R10: `sync_det` with `byte_vld` low has no effect on framing, pulses or cause bits.
- R11: All outputs are registered and change in the cycle after the clock edge that takes the byte in. `sof` is high for one cycle per start. `sec_short` and `sec_long` are updated only at sector starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_resync | input | 1 | 1: misplaced sync restarts the sector; 0: it is discarded |
| cfg_long_win | input | $clog2(MAX_WIN+1) | Long-sector window in bytes, clamped to MAX_WIN |
| byte_vld | input | 1 | A stream byte is present this cycle |
| sync_det | input | 1 | The present byte carries a sync pattern |
| ack | input | 5 | Write-one-to-clear for the cause bits |
| sof | output | 1 | Sector start pulse |
| sof_interp | output | 1 | The start in `sof` was interpolated |
| sec_short | output | 1 | The sector closed at the last start was cut short |
| sec_long | output | 1 | The sector closed at the last start ran long |
| cause | output | 5 | Sticky anomaly causes: 0 ignored, 1 interpolated, 2 resync, 3 short, 4 long |
| irq | output | 1 | Anomaly interrupt request level |

## Verification
The assertions assume that `sync_det` only has meaning when `byte_vld` is high. They also assume that `cfg_resync` and `cfg_long_win` stay fixed while a sector is extended past its nominal length. The stimulus changes configuration only while reset is held, and it raises `sync_det` in idle cycles only to confirm that such syncs are dropped. The sweep places a single sync at every position up to two bytes past the clamped cap, for both policies and several window values.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int NCAUSE   = 5;
  localparam int C_IGN    = 0;
  localparam int C_INTERP = 1;
  localparam int C_RESYNC = 2;
  localparam int C_SHORT  = 3;
  localparam int C_LONG   = 4;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } trk_state_e;

  typedef struct packed {
    logic              start;
    logic              interp;
    logic              shrt;
    logic              lng;
    logic [NCAUSE-1:0] ev;
    logic              restart;
    logic              advance;
    logic              lock;
  } decision_t;
endpackage

// File: rtl/sst_win_clamp.sv
module sst_win_clamp #(
  parameter int SECTOR_LEN = 2352,
  parameter int MAX_WIN    = 16,
  parameter int WIN_W      = $clog2(MAX_WIN + 1),
  parameter int CNT_W      = $clog2(SECTOR_LEN + MAX_WIN + 1)
) (
  input  logic [WIN_W-1:0] cfg_long_win,
  output logic             win_zero,
  output logic [CNT_W-1:0] cap_pos
);
  localparam logic [WIN_W-1:0] MAXW = WIN_W'(MAX_WIN);
  localparam logic [CNT_W-1:0] LEN  = CNT_W'(SECTOR_LEN);

  logic [WIN_W-1:0] win_eff;

  always_comb begin
    win_eff  = (cfg_long_win > MAXW) ? MAXW : cfg_long_win;
    win_zero = (win_eff == '0);
    cap_pos  = LEN + CNT_W'(win_eff);
  end
endmodule

// File: rtl/sst_pos_counter.sv
module sst_pos_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (restart) begin
      pos <= CNT_W'(1);
    end else if (advance) begin
      pos <= pos + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sst_decide.sv
module sst_decide
  import sst_pkg::*;
#(
  parameter int SECTOR_LEN = 2352,
  parameter int CNT_W      = 12
) (
  input  logic             locked,
  input  logic             byte_vld,
  input  logic             sync_det,
  input  logic             cfg_resync,
  input  logic             win_zero,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] cap_pos,
  output decision_t        dec
);
  localparam logic [CNT_W-1:0] LEN = CNT_W'(SECTOR_LEN);

  always_comb begin
    dec = '0;
    if (byte_vld) begin
      if (!locked) begin
        if (sync_det) begin
          dec.start   = 1'b1;
          dec.lock    = 1'b1;
          dec.restart = 1'b1;
        end
      end else if (pos < LEN) begin
        if (sync_det && cfg_resync) begin
          dec.start            = 1'b1;
          dec.restart          = 1'b1;
          dec.shrt             = 1'b1;
          dec.ev[C_RESYNC]     = 1'b1;
          dec.ev[C_SHORT]      = 1'b1;
        end else begin
          dec.advance          = 1'b1;
          dec.ev[C_IGN]        = sync_det;
        end
      end else if (pos == LEN) begin
        if (sync_det) begin
          dec.start   = 1'b1;
          dec.restart = 1'b1;
        end else if (!cfg_resync || win_zero) begin
          dec.start            = 1'b1;
          dec.interp           = 1'b1;
          dec.restart          = 1'b1;
          dec.ev[C_INTERP]     = 1'b1;
        end else begin
          dec.advance = 1'b1;
        end
      end else begin
        if (sync_det && cfg_resync) begin
          dec.start            = 1'b1;
          dec.restart          = 1'b1;
          dec.lng              = 1'b1;
          dec.ev[C_RESYNC]     = 1'b1;
          dec.ev[C_LONG]       = 1'b1;
        end else if (pos >= cap_pos) begin
          dec.start            = 1'b1;
          dec.interp           = 1'b1;
          dec.restart          = 1'b1;
          dec.lng              = 1'b1;
          dec.ev[C_INTERP]     = 1'b1;
          dec.ev[C_LONG]       = 1'b1;
          dec.ev[C_IGN]        = sync_det;
        end else begin
          dec.advance          = 1'b1;
          dec.ev[C_IGN]        = sync_det;
        end
      end
    end
  end
endmodule

// File: rtl/sst_cause_reg.sv
module sst_cause_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  output logic [N-1:0] cause,
  output logic         irq
);
  logic [N-1:0] cause_nxt;

  always_comb begin
    cause_nxt = (cause & ~ack) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      irq   <= 1'b0;
    end else begin
      cause <= cause_nxt;
      irq   <= |cause_nxt;
    end
  end
endmodule

// File: rtl/sst_tracker.sv
module sst_tracker
  import sst_pkg::*;
#(
  parameter int SECTOR_LEN = 2352,
  parameter int MAX_WIN    = 16,
  localparam int WIN_W     = $clog2(MAX_WIN + 1),
  localparam int CNT_W     = $clog2(SECTOR_LEN + MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_resync,
  input  logic [WIN_W-1:0]  cfg_long_win,
  input  logic              byte_vld,
  input  logic              sync_det,
  input  logic [NCAUSE-1:0] ack,
  output logic              sof,
  output logic              sof_interp,
  output logic              sec_short,
  output logic              sec_long,
  output logic [NCAUSE-1:0] cause,
  output logic              irq
);
  trk_state_e       state;
  decision_t        dec;
  logic [CNT_W-1:0] pos_cnt;
  logic [CNT_W-1:0] cap_pos;
  logic             win_zero;

  sst_win_clamp #(
    .SECTOR_LEN(SECTOR_LEN), .MAX_WIN(MAX_WIN), .WIN_W(WIN_W), .CNT_W(CNT_W)
  ) u_clamp (
    .cfg_long_win(cfg_long_win),
    .win_zero    (win_zero),
    .cap_pos     (cap_pos)
  );

  sst_decide #(.SECTOR_LEN(SECTOR_LEN), .CNT_W(CNT_W)) u_decide (
    .locked    (state == ST_LOCKED),
    .byte_vld  (byte_vld),
    .sync_det  (sync_det),
    .cfg_resync(cfg_resync),
    .win_zero  (win_zero),
    .pos       (pos_cnt),
    .cap_pos   (cap_pos),
    .dec       (dec)
  );

  sst_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .restart(dec.restart),
    .advance(dec.advance),
    .pos    (pos_cnt)
  );

  sst_cause_reg #(.N(NCAUSE)) u_cause (
    .clk  (clk),
    .rst  (rst),
    .set  (dec.ev),
    .ack  (ack),
    .cause(cause),
    .irq  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SEARCH;
      sof        <= 1'b0;
      sof_interp <= 1'b0;
      sec_short  <= 1'b0;
      sec_long   <= 1'b0;
    end else begin
      if (dec.lock) state <= ST_LOCKED;
      sof        <= dec.start;
      sof_interp <= dec.interp;
      if (dec.start) begin
        sec_short <= dec.shrt;
        sec_long  <= dec.lng;
      end
    end
  end
endmodule

// File: rtl/sst_tracker_chk.sv
module sst_tracker_chk #(
  parameter int SECTOR_LEN = 2352,
  parameter int MAX_WIN    = 16,
  localparam int CNT_W     = $clog2(SECTOR_LEN + MAX_WIN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_vld,
  input logic [4:0]       ack,
  input logic             sof,
  input logic             sof_interp,
  input logic             sec_short,
  input logic             sec_long,
  input logic [4:0]       cause,
  input logic             irq,
  input logic [CNT_W-1:0] pos_cnt
);
  assert_sof_needs_byte_R11: assert property (@(posedge clk) disable iff (rst)
    sof |-> $past(byte_vld));

  assert_interp_with_sof_R5: assert property (@(posedge clk) disable iff (rst)
    sof_interp |-> sof);

  assert_size_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(sec_short && sec_long));

  assert_irq_is_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (|cause));

  assert_idle_no_effect_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(byte_vld) && $past(ack) == '0) |-> (!sof && $stable(cause)));

  assert_short_sets_causes_R6: assert property (@(posedge clk) disable iff (rst)
    (sof && sec_short) |-> (cause[3] && cause[2]));

  assert_long_sets_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (sof && sec_long) |-> cause[4]);

  assert_pos_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    pos_cnt <= CNT_W'(SECTOR_LEN + MAX_WIN));
endmodule

bind sst_tracker sst_tracker_chk #(.SECTOR_LEN(SECTOR_LEN), .MAX_WIN(MAX_WIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .byte_vld  (byte_vld),
  .ack       (ack),
  .sof       (sof),
  .sof_interp(sof_interp),
  .sec_short (sec_short),
  .sec_long  (sec_long),
  .cause     (cause),
  .irq       (irq),
  .pos_cnt   (pos_cnt)
);

// File: tb/sst_tracker_tb.sv
`timescale 1ns/1ps
module sst_tracker_tb;
  localparam int L    = 12;
  localparam int MW   = 16;
  localparam int WW   = $clog2(MW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_resync = 1'b0;
  logic [WW-1:0] cfg_long_win = '0;
  logic byte_vld = 1'b0;
  logic sync_det = 1'b0;
  logic [4:0] ack = '0;
  logic sof, sof_interp, sec_short, sec_long, irq;
  logic [4:0] cause;

  int n_chk = 0;
  int n_err = 0;

  // bench-side expectation state
  bit m_locked;
  int m_pos;
  bit e_sof, e_int, e_sh, e_lg;
  logic [4:0] e_cause;
  string m_tag;

  always #4 clk = ~clk;

  sst_tracker #(.SECTOR_LEN(L), .MAX_WIN(MW)) u_dut (
    .clk(clk), .rst(rst), .cfg_resync(cfg_resync), .cfg_long_win(cfg_long_win),
    .byte_vld(byte_vld), .sync_det(sync_det), .ack(ack),
    .sof(sof), .sof_interp(sof_interp), .sec_short(sec_short), .sec_long(sec_long),
    .cause(cause), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "sof", int'(sof), int'(e_sof));
    chk(tag, "sof_interp", int'(sof_interp), int'(e_int));
    chk(tag, "sec_short", int'(sec_short), int'(e_sh));
    chk(tag, "sec_long", int'(sec_long), int'(e_lg));
    chk(tag, "cause", int'(cause), int'(e_cause));
    chk("R9", "irq", int'(irq), int'(|e_cause));
  endtask

  task automatic start_sector(input bit interp, input bit sh, input bit lg);
    e_sof = 1'b1; e_int = interp; e_sh = sh; e_lg = lg; m_pos = 1;
  endtask

  // expectations computed from the requirements
  task automatic model_byte(input bit s, input logic [4:0] a);
    int w;
    logic [4:0] ev;
    w = (int'(cfg_long_win) > MW) ? MW : int'(cfg_long_win);
    ev = '0; e_sof = 1'b0; e_int = 1'b0; m_tag = "R11";
    if (!m_locked) begin
      m_tag = "R2";
      if (s) begin m_locked = 1'b1; start_sector(0, 0, 0); end
    end else if (m_pos < L) begin
      if (s && cfg_resync) begin m_tag = "R6"; start_sector(0, 1, 0); ev = 5'b01100; end
      else begin if (s) begin m_tag = "R4"; ev = 5'b00001; end m_pos++; end
    end else if (m_pos == L) begin
      if (s) begin m_tag = "R3"; start_sector(0, 0, 0); end
      else if (!cfg_resync || w == 0) begin m_tag = "R5"; start_sector(1, 0, 0); ev = 5'b00010; end
      else m_pos++;
    end else begin
      if (s && cfg_resync) begin m_tag = "R7"; start_sector(0, 0, 1); ev = 5'b10100; end
      else if (m_pos >= L + w) begin
        m_tag = "R8"; start_sector(1, 0, 1); ev = {3'b100, 1'b1, s};
      end else begin if (s) ev = 5'b00001; m_pos++; end
    end
    e_cause = (e_cause & ~a) | ev;
  endtask

  task automatic byte_cyc(input bit s, input logic [4:0] a);
    @(negedge clk);
    byte_vld = 1'b1; sync_det = s; ack = a;
    model_byte(s, a);
    @(posedge clk); #1;
    check_all(m_tag);
    byte_vld = 1'b0; sync_det = 1'b0; ack = '0;
  endtask

  task automatic idle_cyc(input bit s, input logic [4:0] a, input string tag);
    @(negedge clk);
    byte_vld = 1'b0; sync_det = s; ack = a;
    e_sof = 1'b0; e_int = 1'b0;
    e_cause = e_cause & ~a;
    @(posedge clk); #1;
    check_all(tag);
    sync_det = 1'b0; ack = '0;
  endtask

  task automatic do_reset(input bit pol, input int win);
    @(negedge clk);
    rst = 1'b1; cfg_resync = pol; cfg_long_win = WW'(win);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_locked = 1'b0; m_pos = 0;
    e_sof = 0; e_int = 0; e_sh = 0; e_lg = 0; e_cause = '0;
    @(posedge clk); #1;
    check_all("R1");
  endtask

  initial begin
    int wins[5] = '{0, 1, 3, 16, 20};
    for (int pol = 0; pol < 2; pol++) begin
      for (int wi = 0; wi < 5; wi++) begin
        int weff;
        weff = (wins[wi] > MW) ? MW : wins[wi];
        do_reset(pol[0], wins[wi]);
        byte_cyc(0, '0);
        byte_cyc(0, '0);
        idle_cyc(1, '0, "R10");
        byte_cyc(1, '0);
        for (int p = 1; p <= L + weff + 2; p++) begin
          for (int i = 1; i <= p; i++) begin
            byte_cyc(i == p, '0);
            if (i == 2) idle_cyc(1, '0, "R10");
          end
          idle_cyc(0, 5'b11111, "R9");
        end
        for (int i = 0; i < 3 * (L + weff); i++) byte_cyc(0, '0);
        idle_cyc(0, 5'b00010, "R9");
        idle_cyc(0, 5'b11111, "R9");
      end
    end
    // set wins over a simultaneous acknowledge
    do_reset(1'b0, 0);
    byte_cyc(1, '0);
    for (int i = 1; i < L; i++) byte_cyc(0, '0);
    byte_cyc(0, 5'b11111);
    chk("R9", "set_wins", int'(cause[1]), 1);
    byte_cyc(1, 5'b00010);
    idle_cyc(0, 5'b00001, "R9");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule